// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer with a small synchronous register port. The input clock feeds a programmable first-stage divider (8-bit value plus one), then a second stage that divides by 16, 32, 64 or 128. Each pulse from this chain is a tick, and each tick steps a 16-bit down-counter. When a tick finds the counter at zero, the counter reloads from the reload register. That expiry can raise a one-cycle interrupt pulse, start a stretched reset request, or do both. Software keeps the system alive by writing the counter register before it runs out.

A two-state machine produces the reset request. IDLE leaves the request low. On an expiry with the reset enable set, the ARM transition moves it to HOLD. HOLD drives the request high. A further expiry while in HOLD takes the RETRIGGER transition: the machine stays in HOLD and restarts the hold count. When the hold count completes, the RELEASE transition returns it to IDLE. To stop the watchdog, software clears the count and reset enables. To restart it, software writes the reload value, then the counter, then the control word.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control word reads 0x00008021 (prescale 0x80, divide code 00, counting on, reset on, interrupt off), and both the counter and the reload register read 0x00008000.
- R2: Byte offset 0x00 is control, 0x04 is reload data (low 16 bits kept) and 0x08 is the live counter. Control bits are: 0 reset enable, 2 interrupt enable, 4:3 divide code, 5 count enable, 15:8 prescale. Every other control bit reads 0, and an unmapped offset reads 0.
- R3: While counting, one tick occurs every (P+1)*D input clocks, where P is the prescale and the divide code 00/01/10/11 gives D = 16/32/64/128. The first tick comes exactly (P+1)*D clocks after the control write that enables counting.
- R4: Each tick lowers a non-zero counter by one, and the counter register reads the live value.
- R5: A tick that finds the counter at zero is an expiry. It reloads the counter from the reload register, so the first expiry comes (N+1) ticks after the counter is loaded with N.
- R6: On an expiry with interrupt enable set, the interrupt output is high for exactly one cycle, the cycle after the expiring edge.
- R7: On an expiry with reset enable set, the reset request rises in the cycle after the expiring edge and stays high for 128 cycles. An expiry during the hold restarts the 128-cycle count.
- R8: A write to the counter loads the value at once and takes priority over a tick in the same cycle. Writing the counter regularly prevents any expiry.
- R9: With count enable clear, the counter holds its value and both divider stages are cleared, so a later enable restarts the full tick period.
- R10: With interrupt enable clear, an expiry leaves the interrupt output low. With reset enable clear, an expiry leaves the reset request low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock for all logic and the divider chain |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | One-cycle expiry interrupt |
| rst_req | output | 1 | Stretched reset request |

## Verification
The assertions rely on a tick period of at least 16 clocks, so two expiries can never fall on consecutive edges. They also rely on writes being synchronous, single-cycle strobes. The stimulus meets both conditions. It drives every write between clock edges for exactly one cycle. It reprograms the prescale, the divide code and the reload value only after writing a control word with counting off, following the reload, counter, control restart order. This means no divider setting changes while a count is in progress.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned OFS_CTRL = 8'h00;
    localparam int unsigned OFS_LOAD = 8'h04;
    localparam int unsigned OFS_CNT  = 8'h08;

    localparam int unsigned B_RST  = 0;
    localparam int unsigned B_IRQ  = 2;
    localparam int unsigned B_DIVL = 3;
    localparam int unsigned B_RUN  = 5;
    localparam int unsigned B_PREL = 8;

    typedef struct packed {
        logic [7:0] prescale;
        logic       run;
        logic [1:0] div_code;
        logic       irq_on;
        logic       rst_on;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{prescale: 8'h80, run: 1'b1, div_code: 2'b00,
                                   irq_on: 1'b0, rst_on: 1'b1};

    typedef enum logic [0:0] {
        RQ_IDLE = 1'b0,
        RQ_HOLD = 1'b1
    } rq_state_e;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
    parameter int unsigned PRE_W     = 8,
    parameter int unsigned SEL_W     = 2,
    parameter int unsigned BASE_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [PRE_W-1:0] prescale_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int unsigned DIV_W = BASE_LOG2 + (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pcnt_q;
    logic [DIV_W-1:0] dcnt_q;
    logic [DIV_W-1:0] dlim;
    logic             stage1;
    logic             dwrap;

    assign dlim   = DIV_W'((1 << (BASE_LOG2 + int'(sel_i))) - 1);
    assign stage1 = (pcnt_q >= prescale_i);
    assign dwrap  = (dcnt_q >= dlim);
    assign tick_o = en_i & stage1 & dwrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            dcnt_q <= '0;
        end else if (!en_i) begin
            pcnt_q <= '0;
            dcnt_q <= '0;
        end else if (stage1) begin
            pcnt_q <= '0;
            dcnt_q <= dwrap ? '0 : dcnt_q + 1'b1;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    assert_div_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (pcnt_q == '0 && dcnt_q == '0));
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int unsigned CNT_W   = 16,
    parameter logic [15:0] RST_VAL = 16'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero  = (cnt_q == '0);
    assign expire_o = tick_i & at_zero & ~load_i;
    assign cnt_o    = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= CNT_W'(RST_VAL);
        else if (load_i)
            cnt_q <= load_val_i;
        else if (tick_i)
            cnt_q <= at_zero ? reload_i : cnt_q - 1'b1;
    end

    assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q == $past(load_val_i));
    assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i) |=> $stable(cnt_q));
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> cnt_q == $past(reload_i));
endmodule

// File: rtl/wdog_rstreq.sv
module wdog_rstreq
    import wdog_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic rst_req_o
);
    localparam int unsigned HCNT_W = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;

    rq_state_e         state_q, state_d;
    logic [HCNT_W-1:0] hcnt_q, hcnt_d;

    always_comb begin
        state_d = state_q;
        hcnt_d  = hcnt_q;
        unique case (state_q)
            RQ_IDLE: begin
                if (fire_i) begin
                    state_d = RQ_HOLD;
                    hcnt_d  = '0;
                end
            end
            RQ_HOLD: begin
                if (fire_i) begin
                    hcnt_d = '0;
                end else if (hcnt_q == HCNT_W'(HOLD_CYC - 1)) begin
                    state_d = RQ_IDLE;
                    hcnt_d  = '0;
                end else begin
                    hcnt_d = hcnt_q + 1'b1;
                end
            end
            default: begin
                state_d = RQ_IDLE;
                hcnt_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RQ_IDLE;
            hcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            hcnt_q  <= hcnt_d;
        end
    end

    always_comb begin
        rst_req_o = (state_q == RQ_HOLD);
    end

    assert_req_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> $past(fire_i));
    assert_req_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req_o) |-> ($past(hcnt_q) == HCNT_W'(HOLD_CYC - 1) && !$past(fire_i)));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned BASE_LOG2 = 4,
    parameter int unsigned HOLD_CYC  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              rst_req
);
    localparam logic [15:0] CNT_RST = 16'h8000;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] cnt;
    logic             sel_ctrl, sel_load, sel_cnt;
    logic             tick, expire, irq_q;

    assign sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
    assign sel_load = (addr == ADDR_W'(OFS_LOAD));
    assign sel_cnt  = (addr == ADDR_W'(OFS_CNT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            load_q <= CNT_W'(CNT_RST);
        end else if (wr_en) begin
            if (sel_ctrl) begin
                ctrl_q.rst_on   <= wdata[B_RST];
                ctrl_q.irq_on   <= wdata[B_IRQ];
                ctrl_q.div_code <= wdata[B_DIVL +: 2];
                ctrl_q.run      <= wdata[B_RUN];
                ctrl_q.prescale <= wdata[B_PREL +: 8];
            end
            if (sel_load)
                load_q <= wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (sel_ctrl) begin
            rdata[B_RST]       = ctrl_q.rst_on;
            rdata[B_IRQ]       = ctrl_q.irq_on;
            rdata[B_DIVL +: 2] = ctrl_q.div_code;
            rdata[B_RUN]       = ctrl_q.run;
            rdata[B_PREL +: 8] = ctrl_q.prescale;
        end else if (sel_load) begin
            rdata[CNT_W-1:0] = load_q;
        end else if (sel_cnt) begin
            rdata[CNT_W-1:0] = cnt;
        end
    end

    wdog_tick_gen #(.PRE_W(8), .SEL_W(2), .BASE_LOG2(BASE_LOG2)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (ctrl_q.run),
        .prescale_i (ctrl_q.prescale),
        .sel_i      (ctrl_q.div_code),
        .tick_o     (tick)
    );

    wdog_count #(.CNT_W(CNT_W), .RST_VAL(CNT_RST)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wr_en & sel_cnt),
        .load_val_i (wdata[CNT_W-1:0]),
        .tick_i     (tick),
        .reload_i   (load_q),
        .cnt_o      (cnt),
        .expire_o   (expire)
    );

    wdog_rstreq #(.HOLD_CYC(HOLD_CYC)) u_rq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_i    (expire & ctrl_q.rst_on),
        .rst_req_o (rst_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= expire & ctrl_q.irq_on;
    end
    assign irq = irq_q;

    assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(ctrl_q.irq_on));
    assert_no_tick_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.run |-> !tick);
endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0]  p;
        logic [1:0]  s;
        logic [15:0] n;
        logic [19:0] cyc;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{p: 8'd0, s: 2'd0, n: 16'd3, cyc: 20'd64},
        '{p: 8'd1, s: 2'd1, n: 16'd2, cyc: 20'd192},
        '{p: 8'd2, s: 2'd2, n: 16'd1, cyc: 20'd384},
        '{p: 8'd0, s: 2'd3, n: 16'd0, cyc: 20'd128},
        '{p: 8'd3, s: 2'd0, n: 16'd5, cyc: 20'd384},
        '{p: 8'd4, s: 2'd1, n: 16'd1, cyc: 20'd320}
    };

    logic        clk = 0, rst_n = 0, wr_en = 0;
    logic [3:0]  addr = 0;
    logic [31:0] wdata = 0, rdata;
    logic        irq, rst_req;
    int checks = 0, errors = 0;

    wdog_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                    .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    function automatic logic [31:0] ctl(input logic [7:0] p, input logic [1:0] s,
                                        input bit run, input bit ie, input bit re);
        return {16'h0, p, 2'b00, run, s, ie, 1'b0, re};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int n, hi;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset values
        rd(4'h0, v); check("R1 ctrl", v, 32'h8021);
        rd(4'h4, v); check("R1 load", v, 32'h8000);
        rd(4'h8, v); check("R1 cnt", v, 32'h8000);
        // R2 map and unused bits
        wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, v); check("R2 ctrl mask", v, 32'hFF3D);
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h1234_ABCD); rd(4'h4, v); check("R2 load low16", v, 32'hABCD);
        rd(4'hC, v); check("R2 unmapped", v, 32'h0);

        // R3 R5 R6 R10 vector table
        foreach (VEC[i]) begin
            wr(4'h0, 32'h0);
            wr(4'h4, 32'(VEC[i].n));
            wr(4'h8, 32'(VEC[i].n));
            wr(4'h0, ctl(VEC[i].p, VEC[i].s, 1, 1, 0));
            n = 0; seen = 0;
            while (!irq && n < 5000) begin
                @(negedge clk); n++;
                if (rst_req) seen = 1;
            end
            check($sformatf("R3 R5 expiry time vec%0d", i), n, VEC[i].cyc);
            rd(4'h8, v); check($sformatf("R5 reload vec%0d", i), v, 32'(VEC[i].n));
            check($sformatf("R10 no rst_req vec%0d", i), seen, 0);
            @(negedge clk); check($sformatf("R6 one-cycle irq vec%0d", i), irq, 0);
        end
        wr(4'h0, 32'h0);

        // R4 live countdown
        wr(4'h4, 32'd100); wr(4'h8, 32'd10);
        wr(4'h0, ctl(8'd0, 2'd0, 1, 0, 0));
        repeat (16) @(negedge clk); rd(4'h8, v); check("R4 first tick", v, 32'd9);
        repeat (32) @(negedge clk); rd(4'h8, v); check("R4 third tick", v, 32'd7);

        // R9 stop holds counter, clears prescaler state
        wr(4'h0, 32'h0);
        rd(4'h8, v); repeat (300) @(negedge clk); rd(4'h8, v2);
        check("R9 counter held", v2, v);
        wr(4'h8, 32'd50);
        wr(4'h0, ctl(8'd0, 2'd0, 1, 0, 0));
        repeat (9) @(negedge clk);
        wr(4'h0, 32'h0);
        wr(4'h0, ctl(8'd0, 2'd0, 1, 0, 0));
        repeat (15) @(negedge clk); rd(4'h8, v); check("R9 no early tick", v, 32'd50);
        @(negedge clk); rd(4'h8, v); check("R9 full period tick", v, 32'd49);
        wr(4'h0, 32'h0);

        // R8 keepalive
        wr(4'h4, 32'd4); wr(4'h8, 32'd4);
        wr(4'h0, ctl(8'd0, 2'd0, 1, 1, 1));
        seen = 0;
        for (int k = 0; k < 10; k++) begin
            repeat (50) begin @(negedge clk); if (irq || rst_req) seen = 1; end
            wr(4'h8, 32'd4);
        end
        check("R8 keepalive no expiry", seen, 0);
        rd(4'h8, v); check("R8 immediate load", v, 32'd4);
        wr(4'h0, 32'h0);

        // R7 reset request stretch, R10 irq gated
        wr(4'h4, 32'd20); wr(4'h8, 32'd0);
        wr(4'h0, ctl(8'd0, 2'd0, 1, 0, 1));
        n = 0; seen = 0;
        while (!rst_req && n < 1000) begin @(negedge clk); n++; end
        check("R7 request after one period", n, 16);
        hi = 0;
        while (rst_req && hi < 1000) begin
            if (irq) seen = 1;
            @(negedge clk); hi++;
        end
        check("R7 hold length", hi, 128);
        check("R10 irq stays low", seen, 0);
        wr(4'h0, 32'h0);

        // R1 reset mid-run
        wr(4'h4, 32'd7); wr(4'h0, 32'h25);
        rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
        rd(4'h0, v); check("R1 ctrl after reset", v, 32'h8021);
        rd(4'h4, v); check("R1 load after reset", v, 32'h8000);
        check("R1 outputs low", {30'h0, irq, rst_req}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule